// File: doc/BRIEF.md
# CPU Clock Source Selector and Ratio Divider

This block produces the processor's clock-enable tick inside one fast system clock domain. Four oscillator sources arrive as single-cycle enable strobes: main, sub, on-chip ring oscillator and PLL. Four select bits choose one of these sources. The main, ring-oscillator and PLL sources then pass through a divider whose ratio comes from a 5-bit division field. The set of ratios is not binary: it is 1, 2, 3, 4, 6, 8, 10, 12, 14 and 16. The sub source and the main source in direct mode skip the divider.

The resulting CPU tick is also the count source for the watchdog. A bus-clock tick at the same rate is gated by an expansion-mode input. The division field has a write port and a readback port. After reset the block runs from main divided by 8. A stop or low-power request forces the field back to divide-by-8, unless the ring oscillator is the requested source, so the processor resumes at medium speed. A change of ratio or source is adopted only at a period boundary.

Top module: `cpuclk_gen`

## Requirements
- R1: After rst_n is released, div_rdata reads 5'b01000 and, with src_sel at 0, cpu_tick repeats every 8 main-source ticks.
- R2: src_sel decodes as follows: 4'b0000 selects main, 4'b0001 selects sub, 4'b0010 selects PLL, 4'b0100 selects the ring oscillator and 4'b1000 selects main in direct mode; every other value selects main.
- R3: For the main, ring-oscillator and PLL sources, the division code sets the ratio. Codes 0 to 7 give 1, 2, 3, 4, 6, 10, 12 and 14, code 9 gives 16, and code 8 or any other code gives 8.
- R4: When sub or main-direct is selected, every source tick produces one cpu_tick, whatever the division field holds.
- R5: A cycle with stop_req or lowpwr_req high, and src_sel not equal to 4'b0100, sets div_rdata to 5'b01000 in the next cycle. This takes priority over a write in the same cycle.
- R6: While src_sel is 4'b0100, stop_req and lowpwr_req leave div_rdata and the tick rate unchanged.
- R7: A cycle with div_wr high and no stop, low-power or reset request loads div_wdata, and div_rdata shows it in the next cycle.
- R8: A new ratio or source takes effect only when the current output period completes. The period in progress keeps its full old length.
- R9: bus_tick equals cpu_tick while expand_mode was high in the previous cycle, and stays low otherwise.
- R10: A cycle with rst_req high restores div_rdata to 5'b01000 in the next cycle and restarts the divider from main divided by 8.
- R11: cpu_tick is a single-cycle pulse. It rises one cycle after the source tick that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_main | input | 1 | Main-source enable strobe |
| tick_sub | input | 1 | Sub-source enable strobe |
| tick_osc | input | 1 | Ring-oscillator enable strobe |
| tick_pll | input | 1 | PLL enable strobe |
| src_sel | input | 4 | Source select bits |
| div_wr | input | 1 | Division field write strobe |
| div_wdata | input | 5 | Division code to write |
| stop_req | input | 1 | Stop-mode entry request |
| lowpwr_req | input | 1 | Low-power-mode entry request |
| rst_req | input | 1 | Synchronous reset request |
| expand_mode | input | 1 | Memory-expansion or processor mode active |
| cpu_tick | output | 1 | CPU clock-enable tick (also the watchdog count source) |
| bus_tick | output | 1 | Bus-clock tick, gated by expand_mode |
| div_rdata | output | 5 | Division field readback |

## Verification
A corrupted division field shows on div_rdata one cycle after the event that caused it. A wrong ratio, source or counter value shows as a wrong spacing between cpu_tick pulses, visible within one output period of at most 16 source ticks. A period cut short at a reconfiguration is caught by timing the interval that straddles the write. A bus gating fault appears as a bus_tick that differs from cpu_tick in the same cycle.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int DIV_W = 5;
    localparam int NSRC  = 4;
    localparam int IDX_W = $clog2(NSRC);

    localparam logic [DIV_W-1:0] DIV8_CODE = 5'b01000;
    localparam logic [DIV_W-1:0] DIV8_RATIO = 5'd8;

    // Physical clock strobe index
    localparam logic [IDX_W-1:0] CK_MAIN = 2'd0;
    localparam logic [IDX_W-1:0] CK_SUB  = 2'd1;
    localparam logic [IDX_W-1:0] CK_OSC  = 2'd2;
    localparam logic [IDX_W-1:0] CK_PLL  = 2'd3;

    typedef enum logic [2:0] {
        SRC_MAIN,
        SRC_MAIN_DIR,
        SRC_SUB,
        SRC_OSC,
        SRC_PLL
    } src_e;

    function automatic src_e decode_sel(input logic [3:0] sel);
        case (sel)
            4'b0001: return SRC_SUB;
            4'b0010: return SRC_PLL;
            4'b0100: return SRC_OSC;
            4'b1000: return SRC_MAIN_DIR;
            default: return SRC_MAIN;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] src_index(input src_e s);
        case (s)
            SRC_SUB: return CK_SUB;
            SRC_OSC: return CK_OSC;
            SRC_PLL: return CK_PLL;
            default: return CK_MAIN;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] code_to_ratio(input logic [DIV_W-1:0] code);
        case (code)
            5'd0:    return 5'd1;
            5'd1:    return 5'd2;
            5'd2:    return 5'd3;
            5'd3:    return 5'd4;
            5'd4:    return 5'd6;
            5'd5:    return 5'd10;
            5'd6:    return 5'd12;
            5'd7:    return 5'd14;
            5'd9:    return 5'd16;
            default: return DIV8_RATIO;
        endcase
    endfunction

endpackage

// File: rtl/cpuclk_sel_dec.sv
module cpuclk_sel_dec
    import cpuclk_pkg::*;
(
    input  logic [3:0] sel,
    input  logic [DIV_W-1:0] code,
    output src_e       req_src,
    output logic       osc_sel,
    output logic [DIV_W-1:0] req_ratio
);
    src_e src_w;

    always_comb begin
        src_w   = decode_sel(sel);
        req_src = src_w;
        osc_sel = (src_w == SRC_OSC);
        if (src_w == SRC_SUB || src_w == SRC_MAIN_DIR) begin
            req_ratio = 5'd1;
        end else begin
            req_ratio = code_to_ratio(code);
        end
    end
endmodule

// File: rtl/cpuclk_div_field.sv
module cpuclk_div_field
    import cpuclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             force_def,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] field
);
    typedef struct packed {
        logic [DIV_W-1:0] code;
    } fld_t;

    fld_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (rst_req || force_def) begin
            fld_d.code = DIV8_CODE;
        end else if (wr) begin
            fld_d.code = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q.code <= DIV8_CODE;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign field = fld_q.code;
endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
    import cpuclk_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [NSRC-1:0]  src_ticks,
    input  src_e             req_src,
    input  logic [DIV_W-1:0] req_ratio,
    output logic             fire,
    output logic             tick
);
    typedef struct packed {
        src_e             src;
        logic [DIV_W-1:0] ratio;
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } dst_t;

    dst_t dv_d, dv_q;
    logic cur_tick;
    logic last_cnt;

    always_comb begin
        cur_tick = src_ticks[src_index(dv_q.src)];
        last_cnt = (dv_q.cnt == CNT_W'(dv_q.ratio - 5'd1));
        fire     = cur_tick && last_cnt;

        dv_d      = dv_q;
        dv_d.tick = 1'b0;
        if (restart) begin
            dv_d.src   = SRC_MAIN;
            dv_d.ratio = DIV8_RATIO;
            dv_d.cnt   = '0;
        end else if (fire) begin
            // period complete: adopt pending configuration
            dv_d.tick  = 1'b1;
            dv_d.cnt   = '0;
            dv_d.src   = req_src;
            dv_d.ratio = req_ratio;
        end else if (cur_tick) begin
            dv_d.cnt = dv_q.cnt + 1'b1;
        end else if (dv_q.cnt == '0) begin
            // idle at a boundary: switching cannot shorten a period
            dv_d.src   = req_src;
            dv_d.ratio = req_ratio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q.src   <= SRC_MAIN;
            dv_q.ratio <= DIV8_RATIO;
            dv_q.cnt   <= '0;
            dv_q.tick  <= 1'b0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign tick = dv_q.tick;
endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
    import cpuclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_main,
    input  logic             tick_sub,
    input  logic             tick_osc,
    input  logic             tick_pll,
    input  logic [3:0]       src_sel,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             stop_req,
    input  logic             lowpwr_req,
    input  logic             rst_req,
    input  logic             expand_mode,
    output logic             cpu_tick,
    output logic             bus_tick,
    output logic [DIV_W-1:0] div_rdata
);
    typedef struct packed {
        logic bus;
    } top_t;

    top_t top_d, top_q;

    logic [NSRC-1:0]  ticks;
    logic [DIV_W-1:0] field;
    logic [DIV_W-1:0] req_ratio;
    src_e             req_src;
    logic             osc_sel;
    logic             force_def;
    logic             fire;

    always_comb begin
        ticks          = '0;
        ticks[CK_MAIN] = tick_main;
        ticks[CK_SUB]  = tick_sub;
        ticks[CK_OSC]  = tick_osc;
        ticks[CK_PLL]  = tick_pll;
    end

    cpuclk_sel_dec u_dec (
        .sel       (src_sel),
        .code      (field),
        .req_src   (req_src),
        .osc_sel   (osc_sel),
        .req_ratio (req_ratio)
    );

    assign force_def = (stop_req || lowpwr_req) && !osc_sel;

    cpuclk_div_field u_fld (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .force_def (force_def),
        .wr        (div_wr),
        .wdata     (div_wdata),
        .field     (field)
    );

    cpuclk_divider #(.CNT_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (rst_req),
        .src_ticks (ticks),
        .req_src   (req_src),
        .req_ratio (req_ratio),
        .fire      (fire),
        .tick      (cpu_tick)
    );

    always_comb begin
        top_d.bus = fire && expand_mode && !rst_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.bus <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_tick  = top_q.bus;
    assign div_rdata = field;
endmodule

// File: rtl/cpuclk_gen_chk.sv
module cpuclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] src_sel,
    input logic       div_wr,
    input logic [4:0] div_wdata,
    input logic       stop_req,
    input logic       lowpwr_req,
    input logic       rst_req,
    input logic       expand_mode,
    input logic       cpu_tick,
    input logic       bus_tick,
    input logic [4:0] div_rdata
);
    // R9
    bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tick |-> cpu_tick);

    // R9
    bus_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tick != cpu_tick) |-> !$past(expand_mode));

    // R5
    force_div8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_req || lowpwr_req) && src_sel != 4'b0100) |=> div_rdata == 5'b01000);

    // R6
    osc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_req || lowpwr_req) && src_sel == 4'b0100 && !div_wr && !rst_req)
        |=> $stable(div_rdata));

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> div_rdata == 5'b01000);

    // R7
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && !stop_req && !lowpwr_req && !rst_req) |=> div_rdata == $past(div_wdata));
endmodule

bind cpuclk_gen cpuclk_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .div_wr      (div_wr),
    .div_wdata   (div_wdata),
    .stop_req    (stop_req),
    .lowpwr_req  (lowpwr_req),
    .rst_req     (rst_req),
    .expand_mode (expand_mode),
    .cpu_tick    (cpu_tick),
    .bus_tick    (bus_tick),
    .div_rdata   (div_rdata)
);

// File: tb/cpuclk_gen_tb.sv
module cpuclk_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_main = 1'b0, tick_sub = 1'b0, tick_osc = 1'b0, tick_pll = 1'b0;
    logic [3:0] src_sel = 4'b0000;
    logic       div_wr = 1'b0;
    logic [4:0] div_wdata = 5'd0;
    logic       stop_req = 1'b0, lowpwr_req = 1'b0, rst_req = 1'b0;
    logic       expand_mode = 1'b1;
    logic       cpu_tick, bus_tick;
    logic [4:0] div_rdata;

    int total = 0;
    int bad = 0;
    int bus_mis = 0;

    // source strobe periods in clk cycles
    localparam int P_MAIN = 2, P_SUB = 5, P_OSC = 3, P_PLL = 1;
    int ph_main = 0, ph_sub = 0, ph_osc = 0, ph_pll = 0;

    always #4 clk = ~clk;   // 125 MHz

    cpuclk_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .tick_main(tick_main), .tick_sub(tick_sub), .tick_osc(tick_osc), .tick_pll(tick_pll),
        .src_sel(src_sel), .div_wr(div_wr), .div_wdata(div_wdata),
        .stop_req(stop_req), .lowpwr_req(lowpwr_req), .rst_req(rst_req),
        .expand_mode(expand_mode),
        .cpu_tick(cpu_tick), .bus_tick(bus_tick), .div_rdata(div_rdata)
    );

    always @(negedge clk) begin
        ph_main <= (ph_main + 1) % P_MAIN;
        ph_sub  <= (ph_sub + 1) % P_SUB;
        ph_osc  <= (ph_osc + 1) % P_OSC;
        ph_pll  <= (ph_pll + 1) % P_PLL;
        tick_main <= (ph_main == 0);
        tick_sub  <= (ph_sub == 0);
        tick_osc  <= (ph_osc == 0);
        tick_pll  <= (ph_pll == 0);
        if (expand_mode && rst_n && (bus_tick !== cpu_tick)) bus_mis <= bus_mis + 1;
    end

    typedef struct packed {
        logic [3:0] sel;
        logic [4:0] code;
        logic [7:0] per;
    } vec_t;

    // sel, code, expected cpu_tick spacing in clk cycles
    localparam vec_t VECS [12] = '{
        '{4'b0000, 5'b01000, 8'd16},  // R3 main /8
        '{4'b0000, 5'b00000, 8'd2},   // R3 main /1
        '{4'b0000, 5'b00010, 8'd6},   // R3 main /3
        '{4'b0100, 5'b00100, 8'd18},  // R2 osc /6
        '{4'b0010, 5'b01001, 8'd16},  // R2 pll /16
        '{4'b0010, 5'b00111, 8'd14},  // R3 pll /14
        '{4'b0001, 5'b00011, 8'd5},   // R4 sub undivided
        '{4'b1000, 5'b00101, 8'd2},   // R4 main direct undivided
        '{4'b0011, 5'b00110, 8'd24},  // R2 invalid select -> main /12
        '{4'b0000, 5'b11111, 8'd16},  // R3 unassigned -> /8
        '{4'b0010, 5'b00101, 8'd10},  // R3 pll /10
        '{4'b0100, 5'b00001, 8'd6}    // R3 osc /2
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cpu_tick) return;
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        wait_tick();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            if (cpu_tick) return;
        end
    endtask

    task automatic write_code(input logic [4:0] c);
        div_wr = 1'b1; div_wdata = c;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int cnt_c, cnt_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(div_rdata == 5'b01000, "R1 reset field", div_rdata, 8);
        measure(n);
        check(n == 16, "R1 reset period", n, 16);

        foreach (VECS[k]) begin
            src_sel = VECS[k].sel;
            write_code(VECS[k].code);
            // R7 readback
            check(div_rdata == VECS[k].code, "R7 readback", div_rdata, VECS[k].code);
            wait_tick(); wait_tick();
            measure(n);
            check(n == int'(VECS[k].per), $sformatf("R2/R3/R4 vec%0d period", k), n, VECS[k].per);
        end
        check(bus_mis == 0, "R9 bus follows cpu", bus_mis, 0);

        // R11 single-cycle pulse at /2 (gap > 1)
        src_sel = 4'b0000; write_code(5'b00001);
        wait_tick(); wait_tick();
        @(negedge clk);
        check(cpu_tick == 1'b0, "R11 single pulse", cpu_tick, 0);

        // R5 stop forces /8
        write_code(5'b00000);
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        check(div_rdata == 5'b01000, "R5 stop force", div_rdata, 8);
        // R5 low-power beats same-cycle write
        div_wr = 1'b1; div_wdata = 5'b00011; lowpwr_req = 1'b1;
        @(negedge clk);
        div_wr = 1'b0; lowpwr_req = 1'b0;
        check(div_rdata == 5'b01000, "R5 force over write", div_rdata, 8);

        // R6 osc exemption
        src_sel = 4'b0100; write_code(5'b00010);
        lowpwr_req = 1'b1; stop_req = 1'b1; @(negedge clk);
        lowpwr_req = 1'b0; stop_req = 1'b0;
        check(div_rdata == 5'b00010, "R6 osc keeps field", div_rdata, 2);
        wait_tick(); wait_tick();
        measure(n);
        check(n == 9, "R6 osc rate kept", n, 9);

        // R10 synchronous reset request
        src_sel = 4'b0000; write_code(5'b00001);
        rst_req = 1'b1; @(negedge clk); rst_req = 1'b0;
        check(div_rdata == 5'b01000, "R10 field restored", div_rdata, 8);
        wait_tick();
        measure(n);
        check(n == 16, "R10 main /8 after request", n, 16);

        // R8 change lands at end of period
        src_sel = 4'b0010; write_code(5'b01001);
        wait_tick(); wait_tick(); wait_tick();
        div_wr = 1'b1; div_wdata = 5'b00000;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            div_wr = 1'b0;
            n++;
            if (cpu_tick) break;
        end
        check(n == 16, "R8 period kept full", n, 16);
        measure(n);
        check(n == 1, "R8 new ratio after boundary", n, 1);

        // R9 gated bus tick
        expand_mode = 1'b0;
        src_sel = 4'b0000; write_code(5'b00001);
        cnt_c = 0; cnt_b = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (cpu_tick) cnt_c++;
            if (bus_tick) cnt_b++;
        end
        check(cnt_b == 0, "R9 bus low when not expanded", cnt_b, 0);
        check(cnt_c > 0, "R9 cpu still ticking", cnt_c, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule